// File: doc/BRIEF.md
# Power-Fail Non-Maskable Interrupt Controller

This block watches an active-low, asynchronous power-fail input. When that input falls, it raises a non-maskable interrupt request to a processor core. The input passes through a two-stage synchronizer. A falling-edge detector then feeds a single pending flag. While that flag is set, the interrupt request output is high.

Software reaches the block through a small register interface with two word offsets. The control register at offset 0 holds two enables. The lock enable stays set until reset. The one-shot enable clears itself when it lets an event through. The status register at offset 1 holds the pending flag, and reading it clears the flag. While the flag is set, further edges are dropped. The handler must therefore read the status register before another event can be raised. The same read lets software discard an edge that appeared while the input was being configured, before it arms the block.

Top module: `pfnmi_top`

## Requirements
- R1: The input passes through two synchronizing flip-flops. When `pwrFailN` goes low ahead of clock edge k and the block is armed with no event pending, `nmiReq` is still low after edge k+1 and high after edge k+2.
- R2: Only a high-to-low transition of the synchronized input creates an event. A rising edge or a steady level changes neither `nmiReq` nor the status register.
- R3: After reset, both enables and the pending flag are 0, `nmiReq` is low and `busRdata` is 0.
- R4: While neither enable is set, a falling edge leaves `nmiReq` low and status bit 0 at 0.
- R5: Writing 1 to control bit 1 (offset 0) sets the lock enable. Later writes cannot clear it. Only reset clears it.
- R6: Control bit 0 (offset 0) is the one-shot enable. A write loads it with the written value. It clears when it lets an event through, unless a control write happens in the same cycle, in which case the written value wins.
- R7: `nmiReq` equals the pending flag, which is status bit 0 at offset 1.
- R8: A status read returns the pending flag in bit 0 and zeros in the other bits, and it clears the flag at the same clock edge.
- R9: A falling edge that arrives while the flag is set is dropped. No count is kept, so a single status read leaves no event behind.
- R10: Writes to the status offset have no effect on the pending flag or on `nmiReq`.
- R11: Read data is registered and valid in the cycle after the access. A control read returns the one-shot enable in bit 0 and the lock enable in bit 1. `busRdata` is 0 in any cycle that follows a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrFailN | input | 1 | Asynchronous active-low power-fail input |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (1) | Word offset: 0 control, 1 status |
| busWdata | input | DATA_W (8) | Write data |
| busRdata | output | DATA_W (8) | Registered read data |
| nmiReq | output | 1 | Non-maskable interrupt request to the core |

## Verification
A wrong pending flag appears on `nmiReq` right after the clock edge where it goes wrong, and on the next status read one cycle after that read. Wrong enable state stays hidden until the next falling edge. It then shows at the port two edges after the synchronized edge as a missing or an extra request, or at once on a control read. The table walks the block through both enable modes, through a dropped second edge and through attempts to clear the lock. Directed tests then pin down the exact synchronizer latency, writes to the status offset and reset while armed.

// File: rtl/pfnmi_pkg.sv
package pfnmi_pkg;
  // register offsets (word addressed)
  localparam int CTRL_OFS = 0;
  localparam int STAT_OFS = 1;
  // control field positions
  localparam int ONESHOT_BIT = 0;
  localparam int LOCK_BIT    = 1;
  // status field position
  localparam int PEND_BIT    = 0;

  typedef struct packed {
    logic wrCtrl;
    logic rdCtrl;
    logic rdStat;
    logic wrStat;
  } pfStrobe_t;
endpackage

// File: rtl/pfnmi_ctrl.sv
module pfnmi_ctrl
  import pfnmi_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output pfStrobe_t         strobe
);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);

  logic hitCtrl;
  logic hitStat;

  always_comb begin
    hitCtrl = busSel && (busAddr == CtrlAddr);
    hitStat = busSel && (busAddr == StatAddr);
    strobe.wrCtrl = hitCtrl &&  busWrite;
    strobe.rdCtrl = hitCtrl && !busWrite;
    strobe.rdStat = hitStat && !busWrite;
    strobe.wrStat = hitStat &&  busWrite;
  end
endmodule

// File: rtl/pfnmi_datapath.sv
module pfnmi_datapath
  import pfnmi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFailN,
  input  pfStrobe_t         strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pending,
  output logic              lockEn,
  output logic              oneShotEn
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic [SYNC_STAGES-1:0] stageIn;
  logic                   synced;
  logic                   delayed;
  logic                   fallEdge;
  logic                   armed;
  logic                   accept;
  logic [DATA_W-1:0]      rdNext;
  logic                   unusedStatWrite;

  // synchronizer: idle level of the input is high
  assign stageIn = {syncChain[SYNC_STAGES-2:0], pwrFailN};
  assign synced  = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      delayed   <= 1'b1;
    end else begin
      syncChain <= stageIn;
      delayed   <= synced;
    end
  end

  assign fallEdge = delayed && !synced;
  assign armed    = lockEn || oneShotEn;
  assign accept   = fallEdge && armed && !pending;

  // lock enable: set-only until reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockEn <= 1'b0;
    else if (strobe.wrCtrl && wdata[LOCK_BIT]) lockEn <= 1'b1;
  end

  // one-shot enable: a write wins over self-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oneShotEn <= 1'b0;
    else if (strobe.wrCtrl) oneShotEn <= wdata[ONESHOT_BIT];
    else if (accept) oneShotEn <= 1'b0;
  end

  // pending flag: accept needs !pending, so set and clear never collide
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else if (accept) pending <= 1'b1;
    else if (strobe.rdStat) pending <= 1'b0;
  end

  always_comb begin
    rdNext = '0;
    if (strobe.rdCtrl) begin
      rdNext[ONESHOT_BIT] = oneShotEn;
      rdNext[LOCK_BIT]    = lockEn;
    end
    if (strobe.rdStat) rdNext[PEND_BIT] = pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else rdata <= rdNext;
  end

  // status is read-only; write strobe and spare data bits are dropped
  assign unusedStatWrite = strobe.wrStat ^ (^wdata);
endmodule

// File: rtl/pfnmi_top.sv
module pfnmi_top
  import pfnmi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFailN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              nmiReq
);
  pfStrobe_t strobe;
  logic      pending;
  logic      lockEn;
  logic      oneShotEn;

  pfnmi_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  pfnmi_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .pwrFailN  (pwrFailN),
    .strobe    (strobe),
    .wdata     (busWdata),
    .rdata     (busRdata),
    .pending   (pending),
    .lockEn    (lockEn),
    .oneShotEn (oneShotEn)
  );

  assign nmiReq = pending;
endmodule

// File: rtl/pfnmi_checker.sv
module pfnmi_checker
  import pfnmi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              nmiReq,
  input logic              lockEn,
  input logic              oneShotEn
);
  logic statRead;
  logic ctrlWrite;
  logic anyRead;
  assign statRead  = busSel && !busWrite && (busAddr == ADDR_W'(STAT_OFS));
  assign ctrlWrite = busSel &&  busWrite && (busAddr == ADDR_W'(CTRL_OFS));
  assign anyRead   = busSel && !busWrite;

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && nmiReq) |=> !nmiReq);

  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    (nmiReq && !statRead) |=> nmiReq);

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    lockEn |=> lockEn);

  assert_disarmed_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiReq && !lockEn && !oneShotEn) |=> !nmiReq);

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rstN)
    !anyRead |=> (busRdata == '0));

  assert_oneshot_spent_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(nmiReq) && !$past(ctrlWrite)) |-> !oneShotEn);
endmodule

bind pfnmi_top pfnmi_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .nmiReq    (nmiReq),
  .lockEn    (lockEn),
  .oneShotEn (oneShotEn)
);

// File: tb/pfnmi_top_test.sv
`timescale 1ns/1ps
module pfnmi_top_test;
  localparam int DW = 8;
  localparam int AW = 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pwrFailN = 1'b1;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          nmiReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfnmi_top #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .pwrFailN(pwrFailN), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .nmiReq(nmiReq)
  );

  // op codes of the vector table
  localparam logic [2:0] OP_WRC  = 3'd0;
  localparam logic [2:0] OP_RDC  = 3'd1;
  localparam logic [2:0] OP_RDS  = 3'd2;
  localparam logic [2:0] OP_FALL = 3'd3;
  localparam logic [2:0] OP_RISE = 3'd4;
  localparam int NVEC = 31;
  // {op, wdata, expected read data, expected nmiReq}
  localparam logic [19:0] VEC [NVEC] = '{
    {OP_RDS,  8'h00, 8'h00, 1'b0},  // 0  R3 reset status
    {OP_FALL, 8'h00, 8'h00, 1'b0},  // 1  R4 disarmed edge
    {OP_RISE, 8'h00, 8'h00, 1'b0},  // 2  R2 rising edge
    {OP_RDS,  8'h00, 8'h00, 1'b0},  // 3  R4 nothing latched
    {OP_WRC,  8'h01, 8'h00, 1'b0},  // 4  R6 set one-shot
    {OP_RDC,  8'h00, 8'h01, 1'b0},  // 5  R11 control readback
    {OP_WRC,  8'h00, 8'h00, 1'b0},  // 6  R6 clear by write
    {OP_RDC,  8'h00, 8'h00, 1'b0},  // 7  R6
    {OP_FALL, 8'h00, 8'h00, 1'b0},  // 8  R6 disarmed again
    {OP_RISE, 8'h00, 8'h00, 1'b0},  // 9
    {OP_WRC,  8'h01, 8'h00, 1'b0},  // 10 R6
    {OP_FALL, 8'h00, 8'h00, 1'b1},  // 11 R7 event raised
    {OP_RDC,  8'h00, 8'h00, 1'b1},  // 12 R6 self-cleared
    {OP_RISE, 8'h00, 8'h00, 1'b1},  // 13 R2
    {OP_RDS,  8'h00, 8'h01, 1'b0},  // 14 R8 read returns and clears
    {OP_RDS,  8'h00, 8'h00, 1'b0},  // 15 R8
    {OP_FALL, 8'h00, 8'h00, 1'b0},  // 16 R6 one-shot spent
    {OP_RISE, 8'h00, 8'h00, 1'b0},  // 17
    {OP_WRC,  8'h02, 8'h00, 1'b0},  // 18 R5 lock
    {OP_RDC,  8'h00, 8'h02, 1'b0},  // 19 R5
    {OP_FALL, 8'h00, 8'h00, 1'b1},  // 20 R5 event
    {OP_RISE, 8'h00, 8'h00, 1'b1},  // 21
    {OP_FALL, 8'h00, 8'h00, 1'b1},  // 22 R9 dropped edge
    {OP_RISE, 8'h00, 8'h00, 1'b1},  // 23
    {OP_RDS,  8'h00, 8'h01, 1'b0},  // 24 R9
    {OP_RDS,  8'h00, 8'h00, 1'b0},  // 25 R9 no count kept
    {OP_WRC,  8'h00, 8'h00, 1'b0},  // 26 R5 try to clear lock
    {OP_RDC,  8'h00, 8'h02, 1'b0},  // 27 R5 lock stays
    {OP_FALL, 8'h00, 8'h00, 1'b1},  // 28 R5 still armed
    {OP_RISE, 8'h00, 8'h00, 1'b1},  // 29
    {OP_RDS,  8'h00, 8'h01, 1'b0}   // 30 R8
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic setInput(input logic level);
    @(negedge clk);
    pwrFailN = level;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 nmiReq after reset", {7'd0, nmiReq}, 8'h00);
    check("R3 rdata after reset", busRdata, 8'h00);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] op;
      logic [DW-1:0] wd, er;
      logic en;
      {op, wd, er, en} = VEC[v];
      case (op)
        OP_WRC: access(1'b1, 1'b0, wd);
        OP_RDC: begin access(1'b0, 1'b0, '0); check($sformatf("vec %0d R11 read", v), busRdata, er); end
        OP_RDS: begin access(1'b0, 1'b1, '0); check($sformatf("vec %0d R8 read", v), busRdata, er); end
        OP_FALL: setInput(1'b0);
        default: setInput(1'b1);
      endcase
      check($sformatf("vec %0d R7 nmiReq", v), {7'd0, nmiReq}, {7'd0, en});
    end

    // R11: idle cycle gives zero read data
    @(negedge clk);
    check("R11 idle rdata", busRdata, 8'h00);

    // R10: status write ignored while pending
    setInput(1'b0);
    check("R10 pending before write", {7'd0, nmiReq}, 8'h01);
    access(1'b1, 1'b1, 8'hFF);
    check("R10 nmiReq after status write", {7'd0, nmiReq}, 8'h01);
    access(1'b1, 1'b1, 8'h00);
    check("R10 nmiReq after zero write", {7'd0, nmiReq}, 8'h01);
    access(1'b0, 1'b1, '0);
    check("R10 status still set", busRdata, 8'h01);
    setInput(1'b1);

    // R1: exact latency, lock still armed
    @(negedge clk);
    pwrFailN = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 not yet raised", {7'd0, nmiReq}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R1 raised on third edge", {7'd0, nmiReq}, 8'h01);
    setInput(1'b1);

    // R3: reset while locked and pending
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R3 nmiReq in reset", {7'd0, nmiReq}, 8'h00);
    rstN = 1'b1;
    access(1'b0, 1'b0, '0);
    check("R3 enables cleared", busRdata, 8'h00);
    setInput(1'b0);
    check("R3 R4 disarmed after reset", {7'd0, nmiReq}, 8'h00);
    access(1'b0, 1'b1, '0);
    check("R4 status after reset edge", busRdata, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule